// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block sits between a display timing generator and a pixel memory for a true-colour panel with a fixed 640 by 480 active area. Software programs a frame base address and a small control register through a 32-bit register port. The timing generator supplies a strobe at the start of each frame and one strobe per displayed pixel. For each pixel the block issues the byte address of that pixel's 32-bit memory word, then takes the word returned from memory and splits it into 8-bit red, green and blue outputs.

Each pixel row occupies a 1024-word stride in memory. Only the first 640 words of a row are ever fetched. The base register keeps only its upper 11 bits, so the row and column counts go straight into the lower address bits and one frame lies inside a 2 MiB aligned window. A rotate option reverses the scan in both directions, which turns the picture by 180 degrees. An enable option blanks the panel. Register writes are held back until the next frame start, so a frame is never torn partway through the scan.

Top module: `scanout_addr_gen`

## Requirements
- R1: After reset, both registers read as zero, blank is high, red, green and blue are zero and fetchValid is low.
- R2: Register index 0 (regAddr bit 2 clear, byte offset 0x0) is the frame base. Only write bits 31:21 are kept. Reads return those bits with bits 20:0 as zero.
- R3: Register index 1 (regAddr bit 2 set, byte offset 0x4) is control: bit 0 is enable and bit 1 is rotate. All other bits are dropped on write and read as zero.
- R4: A register read returns the written value at once. The scan uses a written value only from the next frameStart onward, and a frame already in progress keeps its previous base, enable and rotate.
- R5: A pixelAdvance strobe raises fetchValid in the next cycle, with fetchAddr = {base[31:21], row[8:0], col[9:0], 2'b00} for the pixel being passed.
- R6: frameStart sets row and column to zero. Each pixelAdvance increments the column. After column 639 the column returns to 0 and the row increments, so the address jumps from offset 639*4 to offset 4096.
- R7: Once the last pixel of row 479 has been fetched, further pixelAdvance strobes issue nothing until the next frameStart. When frameStart and pixelAdvance arrive in the same cycle, frameStart wins and no fetch is issued in that cycle.
- R8: With rotate active, the row used in the address is 479 minus row and the column is 639 minus column.
- R9: With enable inactive, blank is high, red, green and blue are zero and fetchValid stays low.
- R10: When pixDataValid is high, the word on pixData is unpacked so that bits 23:16 give red, bits 15:8 give green and bits 7:0 give blue, while bits 31:24 are ignored. The colours appear on the outputs one cycle later and keep their value while pixDataValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset; bit 2 selects the register |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| frameStart | input | 1 | Start-of-frame strobe from the timing generator |
| pixelAdvance | input | 1 | One strobe per displayed pixel |
| fetchValid | output | 1 | fetchAddr holds a pixel address to fetch |
| fetchAddr | output | 32 | Byte address of the pixel word |
| pixData | input | 32 | Pixel word returned from memory |
| pixDataValid | input | 1 | pixData is valid |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |
| blank | output | 1 | High while the display is disabled |

## Verification
The embedded assertions check on every cycle that the scan copy of the registers changes only at a frame start, that the row and column counts stay inside the active area and wrap correctly, that a fetch is issued only while enabled, and that the colour register holds between valid data cycles. The bench scenarios cover the behaviour that depends on exact values. These are the bit masking on register reads, the address layout with and without rotation, the jump from the end of one row to the next, the silence after the last row, and the order of the colour fields in the returned word. The end-of-frame case runs on a second instance built with three rows, so a complete frame fits within the run.

// File: rtl/scan_pkg.sv
package scan_pkg;
  parameter int BASE_KEEP = 11;
  parameter int ROW_W     = 9;
  parameter int COL_W     = 10;
  parameter int WORD_SH   = 2;
  parameter int ADDR_W    = BASE_KEEP + ROW_W + COL_W + WORD_SH;
  parameter int CHAN_W    = 8;
  parameter int NUM_CHAN  = 3;

  // strobes and operands handed from control to datapath each cycle
  typedef struct packed {
    logic                 issue;
    logic                 enable;
    logic [BASE_KEEP-1:0] baseHi;
    logic [ROW_W-1:0]     rowEff;
    logic [COL_W-1:0]     colEff;
  } scan_strb_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        frameStart,
  input  logic        pixelAdvance,
  output scan_strb_t  strb
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_ACTIVE - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_ACTIVE - 1);
  localparam int LOW_ZERO = 32 - BASE_KEEP;

  logic [BASE_KEEP-1:0] baseShadow, baseAct;
  logic                 enShadow, rotShadow, enAct, rotAct;
  logic [ROW_W-1:0]     row;
  logic [COL_W-1:0]     col;
  logic                 inFrame;
  logic                 selCtrl;

  assign selCtrl = regAddr[2];

  // software-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseShadow <= '0;
      enShadow   <= 1'b0;
      rotShadow  <= 1'b0;
    end else if (regWrEn) begin
      if (selCtrl) begin
        enShadow  <= regWrData[0];
        rotShadow <= regWrData[1];
      end else begin
        baseShadow <= regWrData[31:LOW_ZERO];
      end
    end
  end

  assign regRdData = selCtrl ? {30'd0, rotShadow, enShadow}
                             : {baseShadow, {LOW_ZERO{1'b0}}};

  // scan copies, refreshed only at frame boundaries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAct <= '0;
      enAct   <= 1'b0;
      rotAct  <= 1'b0;
    end else if (frameStart) begin
      baseAct <= baseShadow;
      enAct   <= enShadow;
      rotAct  <= rotShadow;
    end
  end

  // raster position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      row     <= '0;
      col     <= '0;
      inFrame <= 1'b0;
    end else if (frameStart) begin
      row     <= '0;
      col     <= '0;
      inFrame <= 1'b1;
    end else if (pixelAdvance && inFrame) begin
      if (col == COL_LAST) begin
        col <= '0;
        if (row == ROW_LAST) begin
          row     <= '0;
          inFrame <= 1'b0;
        end else begin
          row <= row + ROW_W'(1);
        end
      end else begin
        col <= col + COL_W'(1);
      end
    end
  end

  always_comb begin
    strb.issue  = pixelAdvance && !frameStart && inFrame && enAct;
    strb.enable = enAct;
    strb.baseHi = baseAct;
    strb.rowEff = rotAct ? (ROW_LAST - row) : row;
    strb.colEff = rotAct ? (COL_LAST - col) : col;
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable({baseAct, enAct, rotAct})); // R4

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (pixelAdvance && !frameStart && inFrame && col == COL_LAST) |=> (col == '0)); // R6

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (row == '0 && col == '0 && inFrame)); // R6

  AST_SCAN_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    (row <= ROW_LAST && col <= COL_LAST)); // R7
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  scan_strb_t        strb,
  input  logic [31:0]       pixData,
  input  logic              pixDataValid,
  output logic              fetchValid,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [CHAN_W-1:0] red,
  output logic [CHAN_W-1:0] green,
  output logic [CHAN_W-1:0] blue,
  output logic              blank
);
  localparam int PIX_W = CHAN_W * NUM_CHAN;

  logic [PIX_W-1:0]  pixReg;
  logic [CHAN_W-1:0] chanOut [NUM_CHAN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchValid <= 1'b0;
      fetchAddr  <= '0;
    end else begin
      fetchValid <= strb.issue;
      if (strb.issue)
        fetchAddr <= {strb.baseHi, strb.rowEff, strb.colEff, {WORD_SH{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pixReg <= '0;
    else if (pixDataValid && strb.enable)
      pixReg <= pixData[PIX_W-1:0];
  end

  // channel 0 = blue (lowest byte), then green, then red
  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    assign chanOut[ch] = strb.enable ? pixReg[ch*CHAN_W +: CHAN_W] : '0;
  end

  assign blue  = chanOut[0];
  assign green = chanOut[1];
  assign red   = chanOut[2];
  assign blank = !strb.enable;

  AST_FETCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> $past(strb.enable)); // R9

  AST_RGB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pixDataValid) |-> $stable(pixReg)); // R10
endmodule

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen
  import scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        frameStart,
  input  logic        pixelAdvance,
  output logic        fetchValid,
  output logic [31:0] fetchAddr,
  input  logic [31:0] pixData,
  input  logic        pixDataValid,
  output logic [7:0]  red,
  output logic [7:0]  green,
  output logic [7:0]  blue,
  output logic        blank
);
  scan_strb_t strb;

  scan_ctrl #(.H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frameStart(frameStart),
    .pixelAdvance(pixelAdvance), .strb(strb)
  );

  scan_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixData(pixData),
    .pixDataValid(pixDataValid), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .red(red), .green(green), .blue(blue), .blank(blank)
  );
endmodule

// File: tb/scanout_addr_gen_bench.sv
module scanout_addr_gen_bench;
  localparam time CLK_P = 8ns;
  localparam int  SHORT_ROWS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic frameStart = 1'b0;
  logic pixelAdvance = 1'b0;
  logic [31:0] pixData = '0;
  logic pixDataValid = 1'b0;

  logic [31:0] rdData, fa, rdDataS, faS;
  logic fv, bl, fvS, blS;
  logic [7:0] r, g, b, rS, gS, bS;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  scanout_addr_gen u_scanout_addr_gen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdData), .frameStart(frameStart),
    .pixelAdvance(pixelAdvance), .fetchValid(fv), .fetchAddr(fa),
    .pixData(pixData), .pixDataValid(pixDataValid),
    .red(r), .green(g), .blue(b), .blank(bl)
  );

  // three-row copy so a whole frame fits in the run
  scanout_addr_gen #(.V_ACTIVE(SHORT_ROWS)) u_scanout_addr_gen_short (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdDataS), .frameStart(frameStart),
    .pixelAdvance(pixelAdvance), .fetchValid(fvS), .fetchAddr(faS),
    .pixData(pixData), .pixDataValid(pixDataValid),
    .red(rS), .green(gS), .blue(bS), .blank(blS)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pixAddr(input logic [31:0] base, input int row, input int col);
    logic [8:0] r9 = 9'(row);
    logic [9:0] c10 = 10'(col);
    return {base[31:21], r9, c10, 2'b00};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string req, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic frame();
    frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
  endtask

  task automatic adv();
    pixelAdvance = 1'b1;
    tick();
    pixelAdvance = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic t_reset();
    rd(4'h0, "R1 base", 32'h0);
    rd(4'h4, "R1 ctrl", 32'h0);
    chk("R1 blank", 32'(bl), 32'd1);
    chk("R1 rgb", {8'h0, r, g, b}, 32'h0);
    chk("R1 fetchValid", 32'(fv), 32'd0);
  endtask

  task automatic t_regs();
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, "R2 base mask", 32'hFFE0_0000);
    wr(4'h0, 32'h001F_FFFF);
    rd(4'h0, "R2 low bits dropped", 32'h0);
    wr(4'h4, 32'hFFFF_FFFC);
    rd(4'h4, "R3 ctrl upper dropped", 32'h0);
    wr(4'h4, 32'h0000_0002);
    rd(4'h4, "R3 rotate bit", 32'h2);
    wr(4'h4, 32'h0);
    rd(4'h0, "R2 base unaffected by ctrl", 32'h0);
  endtask

  task automatic t_deferred();
    wr(4'h4, 32'h1);
    wr(4'h0, 32'h4000_0000);
    chk("R4 enable waits for frame", 32'(bl), 32'd1);
    adv();
    chk("R4 no fetch before frame", 32'(fv), 32'd0);
    frame();
    chk("R4 enable at frame", 32'(bl), 32'd0);
    adv();
    chk("R5 fetchValid", 32'(fv), 32'd1);
    chk("R5 first addr", fa, 32'h4000_0000);
    wr(4'h0, 32'h8000_0000);
    chk("R5 fetchValid drops", 32'(fv), 32'd0);
    rd(4'h0, "R4 read immediate", 32'h8000_0000);
    adv();
    chk("R4 old base mid-frame", fa, pixAddr(32'h4000_0000, 0, 1));
  endtask

  task automatic t_scan();
    frame();
    for (int i = 0; i < 643; i++) begin
      adv();
      chk("R6 scan addr", fa, pixAddr(32'h8000_0000, i / 640, i % 640));
      if (i == 640) chk("R6 row jump", fa, 32'h8000_1000);
    end
  endtask

  task automatic t_endframe();
    frame();
    for (int i = 0; i < 640 * SHORT_ROWS; i++) begin
      adv();
      if (fvS !== 1'b1) chk("R7 full frame valid", 32'(fvS), 32'd1);
    end
    chk("R7 last addr", faS, pixAddr(32'h8000_0000, SHORT_ROWS - 1, 639));
    adv();
    chk("R7 silent after last row", 32'(fvS), 32'd0);
    frameStart = 1'b1; pixelAdvance = 1'b1;
    tick();
    frameStart = 1'b0; pixelAdvance = 1'b0;
    chk("R7 frameStart wins", 32'(fvS), 32'd0);
    adv();
    chk("R7 restart addr", faS, pixAddr(32'h8000_0000, 0, 0));
  endtask

  task automatic t_rotate();
    wr(4'h4, 32'h3);
    frame();
    for (int i = 0; i < 641; i++) begin
      adv();
      if (i == 0 || i == 1 || i == 639 || i == 640)
        chk("R8 rotated addr", fa, pixAddr(32'h8000_0000, 479 - i / 640, 639 - i % 640));
    end
  endtask

  task automatic t_pixel();
    wr(4'h4, 32'h1);
    frame();
    pixData = 32'hAB12_3456; pixDataValid = 1'b1;
    tick();
    pixDataValid = 1'b0; pixData = 32'hFFFF_FFFF;
    chk("R10 unpack", {8'h0, r, g, b}, 32'h0012_3456);
    tick();
    chk("R10 hold", {8'h0, r, g, b}, 32'h0012_3456);
  endtask

  task automatic t_disable();
    wr(4'h4, 32'h0);
    chk("R4 disable waits", 32'(bl), 32'd0);
    frame();
    chk("R9 blank", 32'(bl), 32'd1);
    chk("R9 rgb zero", {8'h0, r, g, b}, 32'h0);
    adv();
    chk("R9 no fetch", 32'(fv), 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rstN = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_deferred();
    t_scan();
    t_endframe();
    t_rotate();
    t_pixel();
    t_disable();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end
endmodule